// File: doc/BRIEF.md
# Conversion Result Holding Register

This block sits on the output side of an analog-to-digital converter. Each time the converter presents a finished sample with a one-cycle valid strobe, the block captures the sample in a data register, marks it unread and raises a conversion-done flag. A read strobe, issued by a bus read or by a DMA acknowledge, consumes the held sample. If a sample arrives while the previous one is still unread, the block records an overrun. It then keeps the old sample or takes the new one, as configured.

The block also issues a level-sensitive DMA request while an unread sample is held. The request runs in one of three modes. In off mode it never asserts. In counted mode it stops after a programmed number of acknowledged transfers. In free-running mode it has no limit. A pending overrun holds the request low until software clears the overrun. Configuration writes are accepted only when the converter reports that no regular conversion is running.

Top module: `conv_result_reg`

## Requirements
- R1: After reset, data_out is 0; data_valid, eoc_flag, ovr_flag, dma_req and irq are 0; cur_overwrite is 0 (keep the old sample); cur_dma_mode is 2'b00 (off).
- R2: A res_valid pulse while data_valid is 0 loads res_data into data_out at the next clock edge and sets data_valid and eoc_flag.
- R3: A rd_strobe clears data_valid and eoc_flag at the next edge. A res_valid in the same cycle as rd_strobe is stored as a normal new sample and does not cause an overrun.
- R4: A res_valid while data_valid is 1 and rd_strobe is 0 sets ovr_flag. With cur_overwrite at 0, data_out keeps the old value.
- R5: With cur_overwrite at 1, the sample that causes the overrun replaces data_out and sets eoc_flag.
- R6: ovr_flag stays set until a cycle with ovr_clr at 1. If a new overrun occurs in that same cycle, the flag stays set.
- R7: eoc_clr at 1 clears eoc_flag without changing data_valid or data_out.
- R8: irq is 1 exactly when (eoc_flag and eoc_ie) or (ovr_flag and ovr_ie).
- R9: cfg_wr is accepted only when busy is 0. While busy is 1, cur_overwrite, cur_dma_mode and the transfer count do not change.
- R10: Mode 2'b01 (counted): dma_req is 1 while data_valid is 1, ovr_flag is 0 and the remaining count is nonzero. Each rd_strobe during a request lowers the count by one. Every accepted cfg_wr reloads the count from cfg_dma_count.
- R11: Mode 2'b10 (free-running): dma_req is 1 for every unread sample with no limit. If a sample is left unread, the next sample sets ovr_flag, and dma_req stays 0 until ovr_flag is cleared.
- R12: Modes 2'b00 and 2'b11 (off): dma_req stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe: new converter sample |
| res_data | input | DATA_W | Converter sample |
| rd_strobe | input | 1 | Read of the data register (bus or DMA acknowledge) |
| busy | input | 1 | Regular conversion in progress |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_overwrite | input | 1 | Overrun policy: 0 keep old, 1 take new |
| cfg_dma_mode | input | 2 | DMA mode: 00 off, 01 counted, 10 free-running, 11 off |
| cfg_dma_count | input | CNT_W | Transfer count for counted mode |
| eoc_ie | input | 1 | Conversion-done interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| eoc_clr | input | 1 | Write-one clear of eoc_flag |
| ovr_clr | input | 1 | Write-one clear of ovr_flag |
| data_out | output | DATA_W | Held sample |
| data_valid | output | 1 | Held sample not yet read |
| eoc_flag | output | 1 | Conversion-done flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| irq | output | 1 | Combined interrupt |
| dma_req | output | 1 | DMA request level |
| cur_overwrite | output | 1 | Overrun policy in force |
| cur_dma_mode | output | 2 | DMA mode in force |

## Verification
The assertions take res_valid and rd_strobe to be single-cycle strobes that are sampled at the clock edge. They also assume configuration changes arrive only through cfg_wr. The bench drives every input one time unit after a rising edge and drops each strobe after exactly one cycle, so no strobe is ever seen at two edges. Sections that need a clean starting state begin with a fresh reset rather than relying on the modes left by earlier sections.

// File: rtl/conv_pkg.sv
// Shared types for the conversion result holding register.
// Assumes a two-bit DMA mode field; code 3 is treated as off.
package conv_pkg;

    typedef enum logic [1:0] {
        DMA_OFF     = 2'b00,
        DMA_COUNTED = 2'b01,
        DMA_FREE    = 2'b10,
        DMA_OFF_ALT = 2'b11
    } dma_mode_e;

    // True when the mode issues requests at all.
    function automatic logic dma_active(input dma_mode_e m);
        return (m == DMA_COUNTED) || (m == DMA_FREE);
    endfunction

endpackage

// File: rtl/conv_cfg.sv
// Configuration holder: overrun policy and DMA mode.
// Accepts a write only while no regular conversion runs (busy low).
// Emits a reload pulse on every accepted write for the transfer counter.
module conv_cfg
    import conv_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             cfg_wr,
    input  logic             cfg_overwrite,
    input  logic [1:0]       cfg_dma_mode,
    input  logic [CNT_W-1:0] cfg_dma_count,
    output logic             overwrite,
    output dma_mode_e        mode,
    output logic             reload,
    output logic [CNT_W-1:0] reload_val
);

    logic accept;

    assign accept     = cfg_wr && !busy;
    assign reload     = accept;
    assign reload_val = cfg_dma_count;

    // Latch policy and mode on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overwrite <= 1'b0;
            mode      <= DMA_OFF;
        end else if (accept) begin
            overwrite <= cfg_overwrite;
            mode      <= dma_mode_e'(cfg_dma_mode);
        end
    end

endmodule

// File: rtl/conv_hold.sv
// Data register with unread, done and overrun flags.
// Assumes res_valid and rd_strobe are one-cycle strobes. A read in the
// same cycle as a new sample frees the register, so no overrun occurs.
module conv_hold #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              rd_strobe,
    input  logic              overwrite,
    input  logic              eoc_clr,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] data_q,
    output logic              valid_q,
    output logic              eoc_q,
    output logic              ovr_q
);

    logic collide;
    logic take;

    assign collide = res_valid && valid_q && !rd_strobe;
    assign take    = res_valid && (!collide || overwrite);

    // Capture a sample when it is not discarded by the keep-old policy.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_q <= '0;
        else if (take) data_q <= res_data;
    end

    // Unread marker: set by a stored sample, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)         valid_q <= 1'b0;
        else if (take)      valid_q <= 1'b1;
        else if (rd_strobe) valid_q <= 1'b0;
    end

    // Done flag: set by a stored sample, cleared by a read or write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)                    eoc_q <= 1'b0;
        else if (take)                 eoc_q <= 1'b1;
        else if (rd_strobe || eoc_clr) eoc_q <= 1'b0;
    end

    // Sticky overrun flag; a new collision wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr_q <= 1'b0;
        else if (collide) ovr_q <= 1'b1;
        else if (ovr_clr) ovr_q <= 1'b0;
    end

endmodule

// File: rtl/conv_dma.sv
// DMA request generator with a transfer counter for counted mode.
// A transfer is counted when a read arrives while the request is high.
// Requests are held off while an overrun is pending.
module conv_dma
    import conv_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dma_mode_e        mode,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             valid_q,
    input  logic             ovr_q,
    input  logic             rd_strobe,
    output logic             dma_req
);

    logic [CNT_W-1:0] left_q;
    logic             budget;

    // Counted mode needs a nonzero budget; free-running always has one.
    always_comb begin
        unique case (mode)
            DMA_COUNTED: budget = (left_q != '0);
            DMA_FREE:    budget = 1'b1;
            default:     budget = 1'b0;
        endcase
    end

    assign dma_req = dma_active(mode) && budget && valid_q && !ovr_q;

    // Remaining-transfer counter: reload on accepted write, count acks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (reload)
            left_q <= reload_val;
        else if (rd_strobe && dma_req && mode == DMA_COUNTED)
            left_q <= left_q - 1'b1;
    end

endmodule

// File: rtl/conv_result_reg.sv
// Conversion result holding register: top level.
// Joins configuration, data holding and DMA request logic and forms
// the combined interrupt. Assumes strobes last one cycle each.
module conv_result_reg
    import conv_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              rd_strobe,
    input  logic              busy,
    input  logic              cfg_wr,
    input  logic              cfg_overwrite,
    input  logic [1:0]        cfg_dma_mode,
    input  logic [CNT_W-1:0]  cfg_dma_count,
    input  logic              eoc_ie,
    input  logic              ovr_ie,
    input  logic              eoc_clr,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] data_out,
    output logic              data_valid,
    output logic              eoc_flag,
    output logic              ovr_flag,
    output logic              irq,
    output logic              dma_req,
    output logic              cur_overwrite,
    output logic [1:0]        cur_dma_mode
);

    dma_mode_e        mode;
    logic             reload;
    logic [CNT_W-1:0] reload_val;

    conv_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .busy          (busy),
        .cfg_wr        (cfg_wr),
        .cfg_overwrite (cfg_overwrite),
        .cfg_dma_mode  (cfg_dma_mode),
        .cfg_dma_count (cfg_dma_count),
        .overwrite     (cur_overwrite),
        .mode          (mode),
        .reload        (reload),
        .reload_val    (reload_val)
    );

    conv_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_data  (res_data),
        .rd_strobe (rd_strobe),
        .overwrite (cur_overwrite),
        .eoc_clr   (eoc_clr),
        .ovr_clr   (ovr_clr),
        .data_q    (data_out),
        .valid_q   (data_valid),
        .eoc_q     (eoc_flag),
        .ovr_q     (ovr_flag)
    );

    conv_dma #(.CNT_W(CNT_W)) u_dma (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .reload     (reload),
        .reload_val (reload_val),
        .valid_q    (data_valid),
        .ovr_q      (ovr_flag),
        .rd_strobe  (rd_strobe),
        .dma_req    (dma_req)
    );

    assign cur_dma_mode = mode;
    assign irq = (eoc_flag && eoc_ie) || (ovr_flag && ovr_ie);

endmodule

// File: rtl/conv_result_reg_chk.sv
// Property checker for conv_result_reg, attached by bind.
// Assumes single-cycle strobes sampled on the rising edge.
module conv_result_reg_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic              rd_strobe,
    input logic              busy,
    input logic              ovr_clr,
    input logic [DATA_W-1:0] data_out,
    input logic              data_valid,
    input logic              eoc_flag,
    input logic              ovr_flag,
    input logic              dma_req,
    input logic              cur_overwrite,
    input logic [1:0]        cur_dma_mode
);

    a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!data_valid && !eoc_flag && !ovr_flag && !dma_req));

    a_r2_store_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !data_valid) |=> (data_valid && eoc_flag && data_out == $past(res_data)));

    a_r4_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && data_valid && !rd_strobe) |=> ovr_flag);

    a_r4_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && data_valid && !rd_strobe && !cur_overwrite) |=> $stable(data_out));

    a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag);

    a_r9_busy_locks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cur_dma_mode) && $stable(cur_overwrite)));

    a_r11_hold_on_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag |-> !dma_req);

    a_r12_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_dma_mode == 2'b00 || cur_dma_mode == 2'b11) |-> !dma_req);

endmodule

bind conv_result_reg conv_result_reg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .res_valid     (res_valid),
    .res_data      (res_data),
    .rd_strobe     (rd_strobe),
    .busy          (busy),
    .ovr_clr       (ovr_clr),
    .data_out      (data_out),
    .data_valid    (data_valid),
    .eoc_flag      (eoc_flag),
    .ovr_flag      (ovr_flag),
    .dma_req       (dma_req),
    .cur_overwrite (cur_overwrite),
    .cur_dma_mode  (cur_dma_mode)
);

// File: tb/conv_result_reg_test.sv
module conv_result_reg_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 12;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          res_valid = 1'b0;
    logic [DW-1:0] res_data = '0;
    logic          rd_strobe = 1'b0;
    logic          busy = 1'b0;
    logic          cfg_wr = 1'b0;
    logic          cfg_overwrite = 1'b0;
    logic [1:0]    cfg_dma_mode = 2'b00;
    logic [CW-1:0] cfg_dma_count = '0;
    logic          eoc_ie = 1'b0;
    logic          ovr_ie = 1'b0;
    logic          eoc_clr = 1'b0;
    logic          ovr_clr = 1'b0;
    logic [DW-1:0] data_out;
    logic          data_valid, eoc_flag, ovr_flag, irq, dma_req, cur_overwrite;
    logic [1:0]    cur_dma_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_result_reg #(.DATA_W(DW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .rd_strobe(rd_strobe), .busy(busy), .cfg_wr(cfg_wr),
        .cfg_overwrite(cfg_overwrite), .cfg_dma_mode(cfg_dma_mode),
        .cfg_dma_count(cfg_dma_count), .eoc_ie(eoc_ie), .ovr_ie(ovr_ie),
        .eoc_clr(eoc_clr), .ovr_clr(ovr_clr), .data_out(data_out),
        .data_valid(data_valid), .eoc_flag(eoc_flag), .ovr_flag(ovr_flag),
        .irq(irq), .dma_req(dma_req), .cur_overwrite(cur_overwrite),
        .cur_dma_mode(cur_dma_mode)
    );

    typedef struct packed {
        logic          rv;
        logic          rd;
        logic          oc;
        logic [DW-1:0] din;
        logic [DW-1:0] xd;
        logic          xv;
        logic          xe;
        logic          xo;
    } vec_t;

    // Keep-old policy walk: R2 store, R4 overrun, R3 read, R6 clear.
    localparam vec_t VEC [0:7] = '{
        '{1'b1, 1'b0, 1'b0, 12'h123, 12'h123, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b0, 1'b0, 12'h456, 12'h123, 1'b1, 1'b1, 1'b1},
        '{1'b0, 1'b1, 1'b0, 12'h000, 12'h123, 1'b0, 1'b0, 1'b1},
        '{1'b0, 1'b0, 1'b1, 12'h000, 12'h123, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b0, 12'h789, 12'h789, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b1, 1'b0, 12'hABC, 12'hABC, 1'b1, 1'b1, 1'b0},
        '{1'b0, 1'b1, 1'b0, 12'h000, 12'hABC, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 12'h000, 12'hABC, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: inputs already set, sample 1 time unit after the edge.
    task automatic tick();
        @(posedge clk);
        #1;
        res_valid = 0; rd_strobe = 0; cfg_wr = 0; eoc_clr = 0; ovr_clr = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; busy = 0; eoc_ie = 0; ovr_ie = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    task automatic sample(input logic [DW-1:0] d);
        res_valid = 1; res_data = d; tick();
    endtask

    task automatic rd();
        rd_strobe = 1; tick();
    endtask

    task automatic cfg(input logic ow, input logic [1:0] m, input logic [CW-1:0] c);
        cfg_wr = 1; cfg_overwrite = ow; cfg_dma_mode = m; cfg_dma_count = c; tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        do_reset();
        // R1 reset state
        chk(data_out == 0 && !data_valid && !eoc_flag && !ovr_flag, "R1 flags", {data_valid, eoc_flag, ovr_flag}, 0);
        chk(!dma_req && !irq, "R1 outputs", {dma_req, irq}, 0);
        chk(!cur_overwrite && cur_dma_mode == 2'b00, "R1 config", {cur_overwrite, cur_dma_mode}, 0);

        // Table walk
        for (int i = 0; i < 8; i++) begin
            res_valid = VEC[i].rv; rd_strobe = VEC[i].rd; ovr_clr = VEC[i].oc;
            res_data = VEC[i].din;
            tick();
            chk(data_out == VEC[i].xd, "R2/R4 data", data_out, VEC[i].xd);
            chk(data_valid == VEC[i].xv, "R3 data_valid", data_valid, VEC[i].xv);
            chk(eoc_flag == VEC[i].xe, "R3 eoc_flag", eoc_flag, VEC[i].xe);
            chk(ovr_flag == VEC[i].xo, "R6 ovr_flag", ovr_flag, VEC[i].xo);
        end

        // R7 eoc clear leaves data
        sample(12'h5A5);
        eoc_clr = 1; tick();
        chk(!eoc_flag, "R7 eoc cleared", eoc_flag, 0);
        chk(data_valid && data_out == 12'h5A5, "R7 data kept", data_out, 12'h5A5);

        // R8 interrupt combination
        rd(); sample(12'h001);
        eoc_ie = 1; #1;
        chk(irq == 1'b1, "R8 eoc irq", irq, 1);
        eoc_ie = 0; #1;
        chk(irq == 1'b0, "R8 masked", irq, 0);
        sample(12'h002);
        chk(irq == 1'b0, "R8 ovr masked", irq, 0);
        ovr_ie = 1; #1;
        chk(irq == 1'b1, "R8 ovr irq", irq, 1);
        // R6 clear and new collision same cycle: set wins
        res_valid = 1; res_data = 12'h003; ovr_clr = 1; tick();
        chk(ovr_flag == 1'b1, "R6 set wins", ovr_flag, 1);
        ovr_clr = 1; tick();
        chk(ovr_flag == 1'b0, "R6 cleared", ovr_flag, 0);

        // R5 overwrite policy
        do_reset();
        cfg(1'b1, 2'b00, 0);
        chk(cur_overwrite == 1'b1, "R5 policy set", cur_overwrite, 1);
        sample(12'h111); sample(12'h222);
        chk(data_out == 12'h222 && ovr_flag, "R5 overwrite", data_out, 12'h222);

        // R9 busy blocks config
        do_reset();
        busy = 1;
        cfg(1'b1, 2'b10, 5);
        chk(!cur_overwrite && cur_dma_mode == 2'b00, "R9 ignored", {cur_overwrite, cur_dma_mode}, 0);
        sample(12'h0AA); sample(12'h0BB);
        chk(data_out == 12'h0AA, "R9 policy unchanged", data_out, 12'h0AA);
        chk(!dma_req, "R9 mode unchanged", dma_req, 0);
        busy = 0;

        // R10 counted mode
        do_reset();
        cfg(1'b0, 2'b01, 2);
        sample(12'h010);
        chk(dma_req, "R10 req 1", dma_req, 1);
        rd();
        chk(!dma_req, "R10 req drop after read", dma_req, 0);
        sample(12'h011);
        chk(dma_req, "R10 req 2", dma_req, 1);
        rd();
        sample(12'h012);
        chk(!dma_req && data_valid, "R10 count exhausted", dma_req, 0);
        rd();
        cfg(1'b0, 2'b01, 1);
        sample(12'h013);
        chk(dma_req, "R10 reload", dma_req, 1);

        // R11 free-running mode
        do_reset();
        cfg(1'b0, 2'b10, 0);
        for (int k = 0; k < 4; k++) begin
            sample(DW'(k + 32));
            chk(dma_req, "R11 req each", dma_req, 1);
            rd();
        end
        sample(12'h0C0); sample(12'h0C1);
        chk(ovr_flag && !dma_req, "R11 overrun stops req", dma_req, 0);
        ovr_clr = 1; tick();
        chk(dma_req, "R11 resumes after clear", dma_req, 1);

        // R12 off codes
        do_reset();
        cfg(1'b0, 2'b11, 3);
        sample(12'h0D0);
        chk(!dma_req && cur_dma_mode == 2'b11, "R12 code 3 off", dma_req, 0);
        rd();
        cfg(1'b0, 2'b00, 3);
        sample(12'h0D1);
        chk(!dma_req, "R12 code 0 off", dma_req, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule